// File: doc/BRIEF.md
# Sixteen-bit ALU with status flag word

This block is the arithmetic-logic unit of a small 16-bit datapath, together with the flag word that sits beside it. Each cycle it takes two operands, an operation code and a size select, and it returns a result at once. Operands are either full 16-bit words or the low bytes of the inputs. The operations are addition and subtraction, each with an optional carry or borrow taken from the stored carry flag. It also does increment, decrement, the bitwise operations, one's complement, and one-bit shifts and rotates.

The flag word is a 16-bit register. It holds six status flags (carry, parity, auxiliary carry, zero, sign, overflow) and three control flags (trap, interrupt enable, direction). When the operation is marked valid, the status flags are updated from the result at the clock edge. The control flags only change through dedicated set and clear inputs or a whole-word load. The register drives the `flags` output directly, and the stored carry feeds the carry-in of the next operation.

Top module: `alu16_flagunit`

## Requirements
- R1: Flag word bit positions are: carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt 9, direction 10, overflow 11. Every other bit always reads 0. Synchronous reset clears the whole word. A load of 16'hFFFF reads back as 16'h0FD5.
- R2: Operation code 0 adds and code 1 adds with the stored carry. Carry is the carry out of the top bit, auxiliary is the carry out of bit 3, and overflow is set when two operands of equal sign give a result of the other sign.
- R3: Code 2 subtracts B from A and code 3 also subtracts the stored carry. Carry is the borrow out of the top bit and auxiliary is the borrow into bit 4. Overflow is set when operands of differing sign give a result whose sign differs from A.
- R4: Code 4 increments A and code 5 decrements A. Both update every status flag except carry, which keeps its stored value.
- R5: Zero is set when the result is zero and sign copies the top bit of the result. Parity is 1 when the low byte of the result holds an even number of ones, in either size.
- R6: Codes 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and NOT A. They clear carry, overflow and auxiliary, and update zero, sign and parity.
- R7: Code 10 shifts left one bit, code 11 shifts right with zero fill and code 12 shifts right keeping the sign. Carry takes the bit shifted out and auxiliary is cleared. Overflow is the new top bit XOR carry for the left shift, the old top bit for the logical right shift, and 0 for the arithmetic right shift.
- R8: Code 13 rotates left and code 14 rotates right, one bit. Carry takes the bit that wrapped around. Overflow is the new top bit XOR carry for the left rotate, and the XOR of the two new top bits for the right rotate. Zero, sign, parity and auxiliary keep their stored values.
- R9: With `word_mode` low, only the low bytes of the operands are used, the top bit is bit 7, and result bits 15:8 are 0.
- R10: Trap, interrupt and direction change only through `ctl_set`/`ctl_clr` (bit 0 trap, bit 1 interrupt, bit 2 direction) or a load. When a bit is both set and cleared in one cycle, the set wins. No operation changes them.
- R11: With `op_valid` low, the status flags keep their values. Code 15 returns A (masked to the operand size) and leaves all flags unchanged.
- R12: A load in a cycle overrides any operation, set or clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Commit this cycle's status flags at the edge |
| op_sel | input | 4 | Operation code |
| word_mode | input | 1 | 1 selects 16-bit operands, 0 selects 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Combinational result |
| flag_load | input | 1 | Replace the whole flag word |
| flag_load_val | input | 16 | Value for the load |
| ctl_set | input | 3 | Set control flags (trap, interrupt, direction) |
| ctl_clr | input | 3 | Clear control flags (trap, interrupt, direction) |
| flags | output | 16 | Stored flag word |

## Verification
The assertions assume the inputs are stable and known at each rising edge. They also assume that any cycle meant to show a result's effect on the flags has `op_valid` set and no load. The stimulus changes inputs only on the falling edge and leaves the edit inputs idle during the operation sweeps. The stored flags are carried forward in the bench model, so the carry-consuming operations see both carry values across the sweep.

// File: rtl/alu16_pkg.sv
// Shared definitions for the ALU and its flag word.
// Assumes a 16-bit flag word; bit positions are fixed by the flag layout.
package alu16_pkg;
    localparam int FLAG_W = 16;
    localparam int FB_CF  = 0;
    localparam int FB_PF  = 2;
    localparam int FB_AF  = 4;
    localparam int FB_ZF  = 6;
    localparam int FB_SF  = 7;
    localparam int FB_TF  = 8;   // trap, interrupt, direction are contiguous from here
    localparam int FB_OF  = 11;
    localparam int CTL_N  = 3;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 16'h0FD5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
        OP_INC = 4'd4, OP_DEC = 4'd5, OP_AND = 4'd6, OP_OR  = 4'd7,
        OP_XOR = 4'd8, OP_NOT = 4'd9, OP_SHL = 4'd10, OP_SHR = 4'd11,
        OP_SAR = 4'd12, OP_ROL = 4'd13, OP_ROR = 4'd14, OP_PASS = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } stat_t;
endpackage

// File: rtl/alu16_addsub.sv
// Adder/subtractor with byte or word width and carry, auxiliary and overflow.
// Assumes W is even and W/2 >= 5 so that bit 4 lies inside a byte operand.
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         word,
    output logic [W-1:0] res,
    output logic         cf,
    output logic         af,
    output logic         of
);
    localparam int H = W / 2;

    logic [W-1:0] beff;
    logic         ci;
    logic [W:0]   wsum;
    logic [H:0]   bsum;
    logic         co, am, bm, rm;

    // Form both widths of a + (b or ~b) + carry, then select by size.
    always_comb begin
        beff = sub ? ~b : b;
        ci   = cin ^ sub;
        wsum = {1'b0, a} + {1'b0, beff} + {{W{1'b0}}, ci};
        bsum = {1'b0, a[H-1:0]} + {1'b0, beff[H-1:0]} + {{H{1'b0}}, ci};
        if (word) begin
            res = wsum[W-1:0];
            co  = wsum[W];
            am  = a[W-1];
            bm  = beff[W-1];
        end else begin
            res = {{H{1'b0}}, bsum[H-1:0]};
            co  = bsum[H];
            am  = a[H-1];
            bm  = beff[H-1];
        end
        rm = word ? res[W-1] : res[H-1];
        cf = co ^ sub;
        af = a[4] ^ b[4] ^ res[4];
        of = (am == bm) && (rm != am);
    end
endmodule

// File: rtl/alu16_bitops.sv
// Bitwise operations and one-bit shifts/rotates with their carry and overflow.
// Assumes op is one of the logic, shift or rotate codes; others yield zero.
module alu16_bitops #(
    parameter int W = 16
) (
    input  alu16_pkg::alu_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic               word,
    output logic [W-1:0]       res,
    output logic               cf,
    output logic               of
);
    import alu16_pkg::*;
    localparam int H = W / 2;

    logic [W-1:0] am, r;
    logic         msb_a, rmsb, rnext;

    // Compute the raw result and carry, then clip to size and derive overflow.
    always_comb begin
        am    = word ? a : {{H{1'b0}}, a[H-1:0]};
        msb_a = word ? a[W-1] : a[H-1];
        r     = '0;
        cf    = 1'b0;
        unique case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_NOT: r = ~a;
            OP_SHL: begin r = am << 1; cf = msb_a; end
            OP_SHR: begin r = am >> 1; cf = a[0]; end
            OP_SAR: begin
                r = am >> 1;
                if (word) r[W-1] = msb_a; else r[H-1] = msb_a;
                cf = a[0];
            end
            OP_ROL: begin r = am << 1; r[0] = msb_a; cf = msb_a; end
            OP_ROR: begin
                r = am >> 1;
                if (word) r[W-1] = a[0]; else r[H-1] = a[0];
                cf = a[0];
            end
            default: r = '0;
        endcase
        if (!word) r[W-1:H] = '0;
        res   = r;
        rmsb  = word ? r[W-1] : r[H-1];
        rnext = word ? r[W-2] : r[H-2];
        unique case (op)
            OP_SHL, OP_ROL: of = rmsb ^ cf;
            OP_SHR:         of = msb_a;
            OP_ROR:         of = rmsb ^ rnext;
            default:        of = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_status.sv
// Zero, sign and parity from a result of either operand size.
// Assumes bits above the byte are already zero in byte mode for zero detect.
module alu16_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  logic         word,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    localparam int H = W / 2;

    // Derive the three result-shape flags.
    always_comb begin
        zf = word ? (res == '0) : (res[H-1:0] == '0);
        sf = word ? res[W-1] : res[H-1];
        pf = ~^res[7:0];
    end
endmodule

// File: rtl/alu16_flagunit.sv
// ALU with its flag word: selects the result by operation code and keeps
// six status flags and three control flags in a fixed sparse layout.
// Assumes inputs are settled at each rising edge; reset is synchronous.
module alu16_flagunit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    input  logic              flag_load,
    input  logic [15:0]       flag_load_val,
    input  logic [2:0]        ctl_set,
    input  logic [2:0]        ctl_clr,
    output logic [15:0]       flags
);
    import alu16_pkg::*;
    localparam int H = DATA_W / 2;

    alu_op_e           op;
    logic [FLAG_W-1:0] flag_q, flag_d;
    logic [DATA_W-1:0] as_b, as_res, bo_res, am;
    logic              as_cin, as_sub, as_cf, as_af, as_of, bo_cf, bo_of;
    logic              st_zf, st_sf, st_pf, is_arith;
    stat_t             st, wr;

    assign op = alu_op_e'(op_sel);

    // Steer operands into the adder for the arithmetic codes.
    always_comb begin
        as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
        as_cin = ((op == OP_ADC) || (op == OP_SBB)) ? flag_q[FB_CF] : 1'b0;
        as_b   = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : opnd_b;
    end

    alu16_addsub #(.W(DATA_W)) addsub_i (
        .a(opnd_a), .b(as_b), .cin(as_cin), .sub(as_sub), .word(word_mode),
        .res(as_res), .cf(as_cf), .af(as_af), .of(as_of)
    );

    alu16_bitops #(.W(DATA_W)) bitops_i (
        .op(op), .a(opnd_a), .b(opnd_b), .word(word_mode),
        .res(bo_res), .cf(bo_cf), .of(bo_of)
    );

    // Pick the result for this code.
    always_comb begin
        am       = word_mode ? opnd_a : {{H{1'b0}}, opnd_a[H-1:0]};
        is_arith = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC});
        if (is_arith)          result = as_res;
        else if (op == OP_PASS) result = am;
        else                    result = bo_res;
    end

    alu16_status #(.W(DATA_W)) status_i (
        .res(result), .word(word_mode), .zf(st_zf), .sf(st_sf), .pf(st_pf)
    );

    // New status values and which of them this code writes.
    always_comb begin
        st.cf = is_arith ? as_cf : bo_cf;
        st.af = is_arith ? as_af : 1'b0;
        st.of = is_arith ? as_of : bo_of;
        st.zf = st_zf;
        st.sf = st_sf;
        st.pf = st_pf;
        unique case (op)
            OP_INC, OP_DEC: wr = '{cf: 1'b0, default: 1'b1};
            OP_ROL, OP_ROR: wr = '{cf: 1'b1, of: 1'b1, default: 1'b0};
            OP_PASS:        wr = '0;
            default:        wr = '1;
        endcase
    end

    // Next flag word: load first, else status update plus control edits.
    always_comb begin
        flag_d = flag_q;
        if (flag_load) begin
            flag_d = flag_load_val & FLAG_MASK;
        end else begin
            if (op_valid) begin
                if (wr.cf) flag_d[FB_CF] = st.cf;
                if (wr.pf) flag_d[FB_PF] = st.pf;
                if (wr.af) flag_d[FB_AF] = st.af;
                if (wr.zf) flag_d[FB_ZF] = st.zf;
                if (wr.sf) flag_d[FB_SF] = st.sf;
                if (wr.of) flag_d[FB_OF] = st.of;
            end
            for (int i = 0; i < CTL_N; i++)
                flag_d[FB_TF+i] = (flag_q[FB_TF+i] & ~ctl_clr[i]) | ctl_set[i];
        end
    end

    // Flag word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;

    // R12
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> flags == ($past(flag_load_val) & FLAG_MASK));

    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_load && ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[FB_TF+CTL_N-1:FB_TF]));

    // R4
    incdec_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && (op inside {OP_INC, OP_DEC})) |=> $stable(flags[FB_CF]));

    // R6
    logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT}))
        |=> (!flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_load) |=> $stable(flags[7:0]) && $stable(flags[FB_OF]));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && !(op inside {OP_ROL, OP_ROR, OP_PASS}))
        |=> flags[FB_ZF] == ($past(result) == '0));
endmodule

// File: tb/alu16_flagunit_tb_top.sv
module alu16_flagunit_tb_top;
    localparam time CLK_P = 10ns;
    localparam int  WATCHDOG_CYC = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        word_mode = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] result;
    logic        flag_load = 1'b0;
    logic [15:0] flag_load_val = '0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] flags;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    logic [15:0] exp_flags = '0;

    always #(CLK_P/2) clk = ~clk;

    alu16_flagunit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .flag_load(flag_load), .flag_load_val(flag_load_val),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(int op);
        case (op)
            0, 1:           return "R2";
            2, 3:           return "R3";
            4, 5:           return "R4";
            6, 7, 8, 9:     return "R6";
            10, 11, 12:     return "R7";
            13, 14:         return "R8";
            default:        return "R11";
        endcase
    endfunction

    // Reference model: returns {new flags, result} from the requirements.
    function automatic logic [31:0] ref_step(int op, bit w, logic [15:0] a, logic [15:0] b,
                                             logic [15:0] fl);
        int mask, msb, maxp, minn, ua, ub, sa, sb, s, full, r, cin;
        bit cf, af, of, wc, wo, wa;
        logic [15:0] nf, rv;
        mask = w ? 32'hFFFF : 32'hFF;
        msb  = w ? 15 : 7;
        maxp = w ? 32767 : 127;
        minn = w ? -32768 : -128;
        ua = int'(a) & mask;
        ub = int'(b) & mask;
        sa = (ua > maxp) ? ua - mask - 1 : ua;
        sb = (ub > maxp) ? ub - mask - 1 : ub;
        cf = 0; af = 0; of = 0; wc = 1; wo = 1; wa = 1; r = 0;
        cin = ((op == 1) || (op == 3)) ? int'(fl[0]) : 0;
        case (op)
            0, 1: begin
                full = ua + ub + cin; r = full & mask; cf = full > mask;
                af = ((ua & 15) + (ub & 15) + cin) > 15;
                s = sa + sb + cin; of = (s > maxp) || (s < minn);
            end
            2, 3: begin
                full = ua - ub - cin; r = full & mask; cf = full < 0;
                af = ((ua & 15) - (ub & 15) - cin) < 0;
                s = sa - sb - cin; of = (s > maxp) || (s < minn);
            end
            4: begin r = (ua + 1) & mask; af = (ua & 15) == 15; of = (sa + 1) > maxp; wc = 0; end
            5: begin r = (ua - 1) & mask; af = (ua & 15) == 0;  of = (sa - 1) < minn; wc = 0; end
            6: r = ua & ub;
            7: r = ua | ub;
            8: r = ua ^ ub;
            9: r = (~ua) & mask;
            10: begin r = (ua << 1) & mask; cf = ((ua >> msb) & 1) != 0;
                      of = (((r >> msb) & 1) != 0) ^ cf; end
            11: begin r = ua >> 1; cf = (ua & 1) != 0; of = ((ua >> msb) & 1) != 0; end
            12: begin r = (ua >> 1) | (ua & (1 << msb)); cf = (ua & 1) != 0; end
            13: begin r = ((ua << 1) | (ua >> msb)) & mask; cf = ((ua >> msb) & 1) != 0;
                      of = (((r >> msb) & 1) != 0) ^ cf; wa = 0; end
            14: begin r = (ua >> 1) | ((ua & 1) << msb); cf = (ua & 1) != 0;
                      of = (((r >> msb) & 1) != 0) ^ (((r >> (msb - 1)) & 1) != 0); wa = 0; end
            default: begin r = ua; wc = 0; wo = 0; wa = 0; end
        endcase
        rv = 16'(r);
        nf = fl;
        if (wc) nf[0] = cf;
        if (wo) nf[11] = of;
        if (wa) begin
            nf[2] = ~^rv[7:0];
            nf[4] = af;
            nf[6] = (rv == 16'h0);
            nf[7] = rv[msb];
        end
        return {nf, rv};
    endfunction

    task automatic run_op(int op, bit w, logic [15:0] a, logic [15:0] b);
        logic [31:0] m;
        string tg;
        tg = w ? op_tag(op) : {op_tag(op), "/R9"};
        @(negedge clk);
        op_valid = 1'b1; op_sel = 4'(op); word_mode = w; opnd_a = a; opnd_b = b;
        m = ref_step(op, w, a, b, exp_flags);
        #1 check({tg, " result"}, result, m[15:0]);
        @(posedge clk);
        #1;
        exp_flags = m[31:16];
        check({tg, "/R5 flags"}, flags, exp_flags);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        logic [15:0] corner [5];
        corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
        corner[3] = 16'h8000; corner[4] = 16'hFFFF;
        lf = 32'h1ACE_B00C;

        // R1: reset dominates an active operation
        op_valid = 1'b1; op_sel = 4'd0; opnd_a = 16'h00FF; opnd_b = 16'h0001;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", flags, 16'h0000);

        // R1: load masks undefined bits
        @(negedge clk); rst_n = 1'b1; op_valid = 1'b0;
        flag_load = 1'b1; flag_load_val = 16'hFFFF;
        @(posedge clk); #1 check("R1 load all ones", flags, 16'h0FD5);

        // R12: load beats operation and set in the same cycle
        @(negedge clk); flag_load_val = 16'h0041; op_valid = 1'b1; op_sel = 4'd0;
        word_mode = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0001; ctl_set = 3'b111;
        @(posedge clk); #1 check("R12 load wins", flags, 16'h0041);

        // R10: set trap and direction
        @(negedge clk); flag_load = 1'b0; op_valid = 1'b0; ctl_set = 3'b101; ctl_clr = 3'b000;
        @(posedge clk); #1 check("R10 set", flags, 16'h0541);

        // R10: clear trap, set and clear interrupt together (set wins)
        @(negedge clk); ctl_set = 3'b010; ctl_clr = 3'b011;
        @(posedge clk); #1 check("R10 set beats clear", flags, 16'h0641);

        // R11: operation without op_valid leaves status alone
        @(negedge clk); ctl_set = '0; ctl_clr = '0; op_valid = 1'b0;
        op_sel = 4'd0; word_mode = 1'b0; opnd_a = 16'h007F; opnd_b = 16'h0001;
        @(posedge clk); #1 check("R11 idle hold", flags, 16'h0641);

        // R10: control clear alongside a word subtraction giving zero
        @(negedge clk); op_valid = 1'b1; op_sel = 4'd2; word_mode = 1'b1;
        opnd_a = 16'h0005; opnd_b = 16'h0005; ctl_clr = 3'b100;
        @(posedge clk); #1 check("R10/R3 ctl with op", flags, 16'h0244);

        // R11: pass code returns masked A, flags unchanged
        @(negedge clk); ctl_clr = '0; op_sel = 4'd15; word_mode = 1'b0; opnd_a = 16'h1234;
        #1 check("R11 pass byte result", result, 16'h0034);
        @(posedge clk); #1 check("R11 pass flags", flags, 16'h0244);
        @(negedge clk); word_mode = 1'b1;
        #1 check("R11 pass word result", result, 16'h1234);

        exp_flags = 16'h0244;

        // Byte sweep: every A against sixteen spread B values, all codes
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    run_op(op, 1'b0, 16'(a), 16'(bi * 17));

        // Word sweep: corner pairs then pseudo-random operands
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 1200; k++) begin
                if (k < 25) run_op(op, 1'b1, corner[k / 5], corner[k % 5]);
                else begin
                    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                    run_op(op, 1'b1, lf[15:0], lf[31:16]);
                end
            end

        // R10: control bits survived the whole sweep
        check("R10 controls after sweep", flags & 16'h0700, 16'h0200);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule